// File: doc/BRIEF.md
# Two-Channel Register-Programmed DMA Engine

This block moves a programmed number of bytes for each of two independent channels. Software writes a memory start address and a byte count into a channel's register window, then writes 1 to that channel's run register. The channel loads its working address and remaining-count registers from the programmed values. It then issues memory beats of up to four bytes through a request/acknowledge handshake until the remaining count reaches zero. At that point the channel stops on its own and records a completion flag.

The two channels share one memory port, and channel 0 wins whenever both want it. Completion flags live in a shared flag register. Software clears a flag by writing ones to a separate clear register. A shared mask register decides which flags drive the single interrupt line. The configuration register and the buffer control register only hold their values; nothing in the data path uses them.

Top module: `dma2_engine`

## Requirements
- R1: After reset, every readable register reads zero, `mem_req` is 0 and `irq` is 0.
- R2: Channel c's registers sit at the channel-0 offset plus 4*c: configuration 0x00, start address 0x10, byte count 0x18, working address 0x20 (read-only), remaining count 0x28 (read-only), run 0x30 (bit 0). The shared registers are: buffer control 0x3C (holds all 32 bits), interrupt mask 0x40 (bit c = channel c), flag register 0x44 (bit c = channel c, read-only), flag clear 0x48. Offset 0x38 reads zero. The configuration register keeps only bits 12, 8 and 5:4; every other bit reads 0.
- R3: Writing 1 to bit 0 of an idle channel's run register makes it busy: run reads 1, the working address equals the start address and the remaining count equals the byte count.
- R4: While busy with a nonzero remaining count, the channel requests a beat with `mem_bytes` = min(4, remaining) and `mem_addr` = working address. Each cycle with `mem_ack` high consumes that beat, adding `mem_bytes` to the working address and subtracting it from the remaining count.
- R5: One cycle after the remaining count reaches zero, run clears by itself and flag bit c sets. At that point the working address equals start address plus byte count.
- R6: Writing 0 to bit 0 of the run register halts the channel at once. The working registers freeze, no further requests are made and no flag is set.
- R7: Writing 1 to bit c of the flag clear register clears flag c. Clear bits written as 0 leave flags unchanged, and writes to the flag register itself are ignored.
- R8: `irq` is the OR over channels of flag AND mask. A flag sets even while its mask bit is 0.
- R9: When both channels request, channel 0 is presented, and `mem_ch` names the presented channel.
- R10: While a channel is busy, writes to its configuration, start address and byte count registers are ignored, and so is another write of 1 to its run register.
- R11: A zero byte count completes one cycle after start with no memory request.
- R12: The byte count register holds 26 bits, so the largest transfer is 2^26-1 bytes and bits 31:26 of a write are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_req | output | 1 | A beat is offered |
| mem_ch | output | 1 | Channel of the offered beat |
| mem_addr | output | 32 | Byte address of the offered beat |
| mem_bytes | output | 3 | Byte count of the offered beat (1 to 4) |
| mem_ack | input | 1 | Beat accepted this cycle |
| irq | output | 1 | Masked completion interrupt |

## Verification
The assertions check on every cycle that a busy channel keeps working address plus remaining count equal to start plus byte count. They also check that every offered beat fits the remaining count and that an accepted beat lowers the count. On top of that, they check that programming registers stay frozen while busy, that at most one channel is granted, that flags stay set until cleared, and that the interrupt needs a mask bit. Only the bench's scenarios can show the actual register offsets and masks, the exact beat sequence for each length and alignment, the one-cycle completion latency and the halt snapshot. The same goes for the clear-register semantics, and for the order in which the two channels are served when both are busy.

// File: rtl/dma2_pkg.sv
package dma2_pkg;
   localparam logic [7:0] OFS_CFG    = 8'h00;
   localparam logic [7:0] OFS_BASE   = 8'h10;
   localparam logic [7:0] OFS_BCNT   = 8'h18;
   localparam logic [7:0] OFS_CUR    = 8'h20;
   localparam logic [7:0] OFS_CCNT   = 8'h28;
   localparam logic [7:0] OFS_RUN    = 8'h30;
   localparam logic [7:0] OFS_BUFC   = 8'h3C;
   localparam logic [7:0] OFS_MASK   = 8'h40;
   localparam logic [7:0] OFS_FLAG   = 8'h44;
   localparam logic [7:0] OFS_FCLR   = 8'h48;
   // configuration bits retained: 12, 8, 5:4
   localparam logic [31:0] CFG_KEEP  = 32'h0000_1130;
endpackage

// File: rtl/dma2_chan.sv
module dma2_chan
   import dma2_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int CNT_W   = 26,
   parameter int BEAT    = 4,
   parameter int CH_OFS  = 0,
   parameter int BYTES_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_i,
   input  logic [7:0]         waddr_i,
   input  logic [31:0]        wdata_i,
   input  logic [7:0]         raddr_i,
   input  logic               grant_i,
   output logic               req_o,
   output logic [ADDR_W-1:0]  addr_o,
   output logic [BYTES_W-1:0] bytes_o,
   output logic               done_o,
   output logic               rd_hit_o,
   output logic [31:0]        rd_data_o
);
   localparam logic [7:0] A_CFG  = 8'(OFS_CFG  + CH_OFS);
   localparam logic [7:0] A_BASE = 8'(OFS_BASE + CH_OFS);
   localparam logic [7:0] A_BCNT = 8'(OFS_BCNT + CH_OFS);
   localparam logic [7:0] A_CUR  = 8'(OFS_CUR  + CH_OFS);
   localparam logic [7:0] A_CCNT = 8'(OFS_CCNT + CH_OFS);
   localparam logic [7:0] A_RUN  = 8'(OFS_RUN  + CH_OFS);
   localparam logic [CNT_W-1:0] BEAT_C = CNT_W'(BEAT);

   logic              run_q;
   logic [31:0]       cfg_q;
   logic [ADDR_W-1:0] base_q, cur_q;
   logic [CNT_W-1:0]  bcnt_q, ccnt_q, step;
   logic              halt_w, start_w, prog_ok;

   assign halt_w  = wr_i && (waddr_i == A_RUN) && !wdata_i[0];
   assign start_w = wr_i && (waddr_i == A_RUN) && wdata_i[0] && !run_q;
   assign prog_ok = wr_i && !run_q;

   always_comb step = (ccnt_q < BEAT_C) ? ccnt_q : BEAT_C;

   assign req_o   = run_q && (ccnt_q != '0);
   assign addr_o  = cur_q;
   assign bytes_o = step[BYTES_W-1:0];
   assign done_o  = run_q && (ccnt_q == '0) && !halt_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         base_q <= '0;
         bcnt_q <= '0;
      end else if (prog_ok) begin
         if (waddr_i == A_CFG)  cfg_q  <= wdata_i & CFG_KEEP;
         if (waddr_i == A_BASE) base_q <= wdata_i[ADDR_W-1:0];
         if (waddr_i == A_BCNT) bcnt_q <= wdata_i[CNT_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         cur_q  <= '0;
         ccnt_q <= '0;
      end else if (halt_w) begin
         run_q <= 1'b0;
      end else if (start_w) begin
         run_q  <= 1'b1;
         cur_q  <= base_q;
         ccnt_q <= bcnt_q;
      end else if (done_o) begin
         run_q <= 1'b0;
      end else if (req_o && grant_i) begin
         cur_q  <= cur_q + ADDR_W'(step);
         ccnt_q <= ccnt_q - step;
      end
   end

   always_comb begin
      rd_hit_o  = 1'b1;
      rd_data_o = '0;
      case (raddr_i)
         A_CFG:  rd_data_o = cfg_q;
         A_BASE: rd_data_o = 32'(base_q);
         A_BCNT: rd_data_o = 32'(bcnt_q);
         A_CUR:  rd_data_o = 32'(cur_q);
         A_CCNT: rd_data_o = 32'(ccnt_q);
         A_RUN:  rd_data_o = {31'd0, run_q};
         default: rd_hit_o = 1'b0;
      endcase
   end

   AST_SUM_INVARIANT: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> (cur_q + ADDR_W'(ccnt_q)) == (base_q + ADDR_W'(bcnt_q))); // R5
   AST_BEAT_FITS: assert property (@(posedge clk) disable iff (!rst_n)
      req_o |-> (bytes_o != '0) && (CNT_W'(bytes_o) <= ccnt_q)); // R4
   AST_CNT_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && grant_i && !halt_w) |=> (ccnt_q < $past(ccnt_q))); // R4
   AST_PROG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |=> $stable(base_q) && $stable(bcnt_q) && $stable(cfg_q)); // R10
   AST_HALT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      halt_w |=> !run_q && !req_o); // R6
endmodule

// File: rtl/dma2_irq.sv
module dma2_irq #(
   parameter int NCH = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           mask_wr_i,
   input  logic           clr_wr_i,
   input  logic [NCH-1:0] wbits_i,
   input  logic [NCH-1:0] done_i,
   output logic [NCH-1:0] mask_o,
   output logic [NCH-1:0] flag_o,
   output logic           irq_o
);
   logic [NCH-1:0] clr_bits;

   assign clr_bits = clr_wr_i ? wbits_i : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_o <= '0;
         flag_o <= '0;
      end else begin
         if (mask_wr_i) mask_o <= wbits_i;
         flag_o <= (flag_o & ~clr_bits) | done_i;
      end
   end

   assign irq_o = |(flag_o & mask_o);

   AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (mask_o != '0)); // R8

   for (genvar c = 0; c < NCH; c++) begin : g_flag_chk
      AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (flag_o[c] && !clr_bits[c]) |=> flag_o[c]); // R7
      AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_bits[c] && !done_i[c]) |=> !flag_o[c]); // R7
   end
endmodule

// File: rtl/dma2_engine.sv
module dma2_engine
   import dma2_pkg::*;
#(
   parameter int NCH       = 2,
   parameter int ADDR_W    = 32,
   parameter int CNT_W     = 26,
   parameter int BEAT      = 4,
   parameter int CH_STRIDE = 4,
   localparam int CH_W     = (NCH > 1) ? $clog2(NCH) : 1,
   localparam int BYTES_W  = $clog2(BEAT + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic [7:0]         reg_addr,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   output logic               mem_req,
   output logic [CH_W-1:0]    mem_ch,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic [BYTES_W-1:0] mem_bytes,
   input  logic               mem_ack,
   output logic               irq
);
   if (NCH < 1 || NCH > 2) begin : g_bad_nch
      $error("dma2_engine: NCH must be 1 or 2");
   end
   if (ADDR_W > 32 || CNT_W > ADDR_W) begin : g_bad_width
      $error("dma2_engine: need CNT_W <= ADDR_W <= 32");
   end
   if (BEAT < 1 || (BEAT & (BEAT - 1)) != 0) begin : g_bad_beat
      $error("dma2_engine: BEAT must be a power of two");
   end
   if (CH_STRIDE % 4 != 0 || CH_STRIDE >= 8) begin : g_bad_stride
      $error("dma2_engine: CH_STRIDE must be 4 to keep channel windows apart");
   end

   logic [NCH-1:0]     req, grant, done, hit, mask, flag;
   logic [ADDR_W-1:0]  caddr  [NCH];
   logic [BYTES_W-1:0] cbytes [NCH];
   logic [31:0]        crd    [NCH];
   logic [31:0]        bufc_q;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      dma2_chan #(
         .ADDR_W (ADDR_W),
         .CNT_W  (CNT_W),
         .BEAT   (BEAT),
         .CH_OFS (c * CH_STRIDE),
         .BYTES_W(BYTES_W)
      ) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_i     (reg_wr),
         .waddr_i  (reg_addr),
         .wdata_i  (reg_wdata),
         .raddr_i  (reg_addr),
         .grant_i  (grant[c]),
         .req_o    (req[c]),
         .addr_o   (caddr[c]),
         .bytes_o  (cbytes[c]),
         .done_o   (done[c]),
         .rd_hit_o (hit[c]),
         .rd_data_o(crd[c])
      );
   end

   // fixed priority: lowest channel index wins the shared port
   always_comb begin
      mem_ch    = '0;
      mem_addr  = '0;
      mem_bytes = '0;
      for (int c = NCH - 1; c >= 0; c--) begin
         if (req[c]) begin
            mem_ch    = CH_W'(c);
            mem_addr  = caddr[c];
            mem_bytes = cbytes[c];
         end
      end
      mem_req = |req;
      for (int c = 0; c < NCH; c++) begin
         grant[c] = mem_ack && req[c] && (mem_ch == CH_W'(c));
      end
   end

   dma2_irq #(.NCH(NCH)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .mask_wr_i(reg_wr && (reg_addr == OFS_MASK)),
      .clr_wr_i (reg_wr && (reg_addr == OFS_FCLR)),
      .wbits_i  (reg_wdata[NCH-1:0]),
      .done_i   (done),
      .mask_o   (mask),
      .flag_o   (flag),
      .irq_o    (irq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               bufc_q <= '0;
      else if (reg_wr && reg_addr == OFS_BUFC) bufc_q <= reg_wdata;
   end

   always_comb begin
      reg_rdata = '0;
      for (int c = 0; c < NCH; c++) begin
         if (hit[c]) reg_rdata = reg_rdata | crd[c];
      end
      case (reg_addr)
         OFS_BUFC: reg_rdata = bufc_q;
         OFS_MASK: reg_rdata = 32'(mask);
         OFS_FLAG: reg_rdata = 32'(flag);
         default:  ;
      endcase
   end

   AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant)); // R9
   AST_LOW_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      req[0] |-> (mem_ch == '0) && mem_req); // R9
endmodule

// File: tb/dma2_engine_bench.sv
module dma2_engine_bench;
   localparam logic [7:0] A_CFG = 8'h00, A_BASE = 8'h10, A_BCNT = 8'h18, A_CUR = 8'h20,
                          A_CCNT = 8'h28, A_RUN = 8'h30, A_HOLE = 8'h38, A_BUFC = 8'h3C,
                          A_MASK = 8'h40, A_FLAG = 8'h44, A_FCLR = 8'h48;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mem_req, mem_ch, irq;
   logic [31:0] mem_addr;
   logic [2:0]  mem_bytes;
   logic        mem_ack = 1'b0;
   int          checks = 0;
   int          errors = 0;

   always #2.5 clk = ~clk;

   dma2_engine u_dma2_engine (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
      .mem_ch(mem_ch), .mem_addr(mem_addr), .mem_bytes(mem_bytes),
      .mem_ack(mem_ack), .irq(irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      reg_addr = a;
      #0.5;
      d = reg_rdata;
   endtask

   task automatic rdchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      chk(tag, v, exp);
   endtask

   // run one transfer with mem_ack held high and check every beat
   task automatic run_xfer(input int ch, input logic [31:0] base, input int len);
      logic [7:0] o;
      int nb;
      o  = 8'(4 * ch);
      nb = (len + 3) / 4;
      mem_ack = 1'b1;
      wr(A_BASE + o, base);
      wr(A_BCNT + o, 32'(len));
      wr(A_RUN + o, 32'd1);
      for (int k = 0; k < nb; k++) begin
         chk("R4 req", 32'(mem_req), 32'd1);
         chk("R9 ch", 32'(mem_ch), 32'(ch));
         chk("R4 addr", mem_addr, base + 32'(4 * k));
         chk("R4 bytes", 32'(mem_bytes), 32'((len - 4 * k) < 4 ? (len - 4 * k) : 4));
         @(negedge clk);
      end
      chk("R11 R4 no req at zero", 32'(mem_req), 32'd0);
      rdchk("R5 end addr", A_CUR + o, base + 32'(len));
      rdchk("R4 count zero", A_CCNT + o, 32'd0);
      @(negedge clk);
      rdchk("R5 run self clears", A_RUN + o, 32'd0);
      rdchk("R5 flag set", A_FLAG, 32'(1 << ch));
   endtask

   initial begin
      int cyc = 0;
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
         end
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      rdchk("R1 cfg0", A_CFG, 0);
      rdchk("R1 base1", A_BASE + 4, 0);
      rdchk("R1 run0", A_RUN, 0);
      rdchk("R1 flag", A_FLAG, 0);
      rdchk("R1 mask", A_MASK, 0);
      chk("R1 mem_req", 32'(mem_req), 0);
      chk("R1 irq", 32'(irq), 0);

      // R2: map and masks
      wr(A_CFG, 32'hFFFF_FFFF);
      rdchk("R2 cfg keep", A_CFG, 32'h0000_1130);
      rdchk("R2 cfg1 separate", A_CFG + 4, 0);
      wr(A_CFG + 4, 32'h0000_0020);
      rdchk("R2 cfg1 wait field", A_CFG + 4, 32'h0000_0020);
      wr(A_BUFC, 32'hA5C3_0F11);
      rdchk("R2 bufc", A_BUFC, 32'hA5C3_0F11);
      rdchk("R2 hole", A_HOLE, 0);
      wr(A_BASE + 4, 32'h1234_5678);
      rdchk("R2 base1", A_BASE + 4, 32'h1234_5678);
      rdchk("R2 base0 untouched", A_BASE, 0);

      // R12: count width
      wr(A_BCNT, 32'hFFFF_FFFF);
      rdchk("R12 count mask", A_BCNT, 32'h03FF_FFFF);

      // R4 R5 R8 R11: sweep lengths and alignments with mask off
      for (int ch = 0; ch < 2; ch++) begin
         for (int len = 0; len < 10; len++) begin
            wr(A_FCLR, 32'h3);
            run_xfer(ch, 32'h1000_0000 + 32'(ch * 256) + 32'(len * 3), len);
            chk("R8 flag without irq", 32'(irq), 0);
         end
      end
      wr(A_FCLR, 32'h3);
      run_xfer(1, 32'h2000_0001, 1000);

      // R7 R8: mask and clear (flag = 2 now)
      wr(A_MASK, 32'h1);
      chk("R8 other mask", 32'(irq), 0);
      wr(A_MASK, 32'h3);
      chk("R8 irq on", 32'(irq), 1);
      wr(A_FCLR, 32'h0);
      rdchk("R7 zero clear no effect", A_FLAG, 32'h2);
      wr(A_FLAG, 32'h0);
      rdchk("R7 flag not writable", A_FLAG, 32'h2);
      wr(A_FCLR, 32'h1);
      rdchk("R7 wrong bit keeps", A_FLAG, 32'h2);
      wr(A_FCLR, 32'h2);
      rdchk("R7 cleared", A_FLAG, 32'h0);
      chk("R8 irq off", 32'(irq), 0);

      // R9: both busy, channel 0 first
      mem_ack = 1'b0;
      wr(A_BASE, 32'h0000_4000); wr(A_BCNT, 8);
      wr(A_BASE + 4, 32'h0000_8000); wr(A_BCNT + 4, 6);
      wr(A_RUN + 4, 1);
      chk("R9 lone ch1", 32'(mem_ch), 1);
      wr(A_RUN, 1);
      chk("R9 ch0 wins", 32'(mem_ch), 0);
      chk("R9 ch0 addr", mem_addr, 32'h0000_4000);
      mem_ack = 1'b1;
      @(negedge clk);
      chk("R9 ch0 beat2", mem_addr, 32'h0000_4004);
      @(negedge clk);
      chk("R9 ch1 after", 32'(mem_ch), 1);
      chk("R9 ch1 addr", mem_addr, 32'h0000_8000);
      @(negedge clk);
      chk("R9 ch1 tail bytes", 32'(mem_bytes), 2);
      @(negedge clk);
      chk("R9 idle", 32'(mem_req), 0);
      @(negedge clk);
      rdchk("R9 both flags", A_FLAG, 32'h3);
      chk("R8 irq both", 32'(irq), 1);
      wr(A_FCLR, 32'h3);

      // R3 R10: start and ignored writes while busy
      mem_ack = 1'b0;
      wr(A_BASE, 32'h0000_0100); wr(A_BCNT, 20);
      wr(A_RUN, 1);
      rdchk("R3 run", A_RUN, 1);
      rdchk("R3 cur addr", A_CUR, 32'h0000_0100);
      rdchk("R3 cur count", A_CCNT, 20);
      wr(A_BASE, 32'hDEAD_0000);
      rdchk("R10 base locked", A_BASE, 32'h0000_0100);
      wr(A_BCNT, 3);
      rdchk("R10 count locked", A_BCNT, 20);
      wr(A_CFG, 0);
      rdchk("R10 cfg locked", A_CFG, 32'h0000_1130);
      mem_ack = 1'b1;
      @(negedge clk);
      mem_ack = 1'b0;
      wr(A_RUN, 1);
      rdchk("R10 restart ignored addr", A_CUR, 32'h0000_0104);
      rdchk("R10 restart ignored count", A_CCNT, 16);

      // R6: halt
      wr(A_RUN, 0);
      rdchk("R6 run cleared", A_RUN, 0);
      chk("R6 no req", 32'(mem_req), 0);
      mem_ack = 1'b1;
      repeat (3) @(negedge clk);
      mem_ack = 1'b0;
      rdchk("R6 addr frozen", A_CUR, 32'h0000_0104);
      rdchk("R6 count frozen", A_CCNT, 16);
      rdchk("R6 no flag", A_FLAG, 0);
      chk("R6 no irq", 32'(irq), 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule